// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a byte-wide register port and runs on one system clock. Software chooses a count source and a power-of-two timeout through a mode register. After that it must keep writing one fixed key byte to a restart register, or the watchdog fires. Two count sources arrive as single-cycle enable pulses in the system clock domain: a fast tick from an internal oscillator and a slow tick at 32.768 kHz. Only the source that the mode selects advances the counter. The mode can also hold the counter stopped.

The restart register guards itself. Only the key byte restarts the count. Any other byte, or a bit-manipulation access, forces an overflow at once. A read of this register returns a constant that differs from the key. The mode register takes one write after reset. That write also restarts the count, and any later write to it forces an overflow. The overflow output is a reset request. Once it is asserted it stays asserted until a system reset.

Top module: `keywdt_top`

## Requirements
- R1: After reset, `overflow` is 0, a read of the mode register returns 0x07 and a read of the restart register returns 0x9A. The counter then runs with mode 0x07 (fast source, n = 7).
- R2: The mode field is `wdata[4:0]`: bit 4 = stop, bit 3 = source select, bits 2..0 = n. With bit 4 = 0 and bit 3 = 0, `overflow` rises on the clock edge that accepts the 2^(FAST_BASE+n)-th fast tick counted since the count last restarted.
- R3: With bit 4 = 0 and bit 3 = 1, `overflow` rises on the clock edge that accepts the 2^(SLOW_BASE+n)-th slow tick.
- R4: With bit 4 = 1 the counter is stopped and no number of ticks produces an overflow.
- R5: Ticks from the source that is not selected do not advance the counter.
- R6: A write (`addr` = 1, `bit_op` = 0) of 0xAC to the restart register clears the counter, and this takes priority over a tick in the same cycle.
- R7: A write to the restart register with any data other than 0xAC raises `overflow` on that clock edge.
- R8: A write to the restart register with `bit_op` = 1 raises `overflow` on that clock edge, whatever the data.
- R9: A read of the restart register (`addr` = 1) always returns 0x9A, whatever was written before.
- R10: The first write to the mode register (`addr` = 0) after reset takes effect and clears the counter. Every later write to it raises `overflow` on its clock edge.
- R11: Once `overflow` is 1 it stays 1 until reset, and key writes no longer have any effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fast_tick | input | 1 | Single-cycle count enable from the fast internal oscillator |
| slow_tick | input | 1 | Single-cycle count enable from the 32.768 kHz source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 = mode, 1 = restart |
| bit_op | input | 1 | Marks the access as a single-bit read-modify-write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register that `addr` selects |
| overflow | output | 1 | Sticky watchdog overflow and reset request |

## Verification
The bench runs every running mode, for both sources and all eight exponents, to exactly one tick before the limit and then one tick past it, while it interleaves pulses from the unselected source. A design with an off-by-one compare, a wrong exponent base or the source mux reversed fires early or late. It writes all 255 non-key bytes to the restart register, and it makes a bit-operation access that carries the key as its data. A design that checks only some bits of the key, or that ignores the sideband flag, misses a trip. It sends a key in the same cycle as a tick, repeats the mode write, and makes key writes after an overflow. These catch a design whose clear loses to an increment, whose once-only lock is missing, or whose overflow can be cancelled.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  typedef struct packed {
    logic       stop;
    logic       slow;
    logic [2:0] sel;
  } kwdt_mode_t;

  localparam logic REG_MODE    = 1'b0;
  localparam logic REG_RESTART = 1'b1;

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter logic [7:0] KEY        = 8'hAC,
  parameter logic [7:0] READBACK   = 8'h9A,
  parameter logic [4:0] RESET_MODE = 5'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic       bit_op,
  input  logic [7:0] wdata,
  output kwdt_mode_t mode,
  output logic       locked,
  output logic       restart_clr,
  output logic       trip,
  output logic [7:0] rdata
);

  kwdt_mode_t mode_q, mode_d;
  logic       locked_q, locked_d;
  logic       mode_wr, restart_wr, key_ok;

  always_comb begin
    mode_wr     = wr_en && (addr == REG_MODE);
    restart_wr  = wr_en && (addr == REG_RESTART);
    key_ok      = restart_wr && !bit_op && (wdata == KEY);
    trip        = (restart_wr && !key_ok) || (mode_wr && locked_q);
    restart_clr = key_ok || (mode_wr && !locked_q);
    mode_d      = mode_q;
    locked_d    = locked_q;
    if (mode_wr && !locked_q) begin
      mode_d   = kwdt_mode_t'(wdata[4:0]);
      locked_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= kwdt_mode_t'(RESET_MODE);
      locked_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      locked_q <= locked_d;
    end
  end

  assign mode   = mode_q;
  assign locked = locked_q;
  assign rdata  = (addr == REG_RESTART) ? READBACK : {3'b000, mode_q};

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int unsigned FAST_BASE = 12,
  parameter int unsigned SLOW_BASE = 9,
  parameter int unsigned CNT_W     = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_tick,
  input  logic             slow_tick,
  input  kwdt_mode_t       mode,
  input  logic             clr,
  input  logic             halt,
  output logic             expire,
  output logic [CNT_W-1:0] cnt
);

  localparam int unsigned EXP_W = $clog2(CNT_W + 1);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d, limit_m1;
  logic [EXP_W-1:0] exp_sel;
  logic             tick;

  always_comb begin
    tick     = !mode.stop && (mode.slow ? slow_tick : fast_tick);
    exp_sel  = (mode.slow ? EXP_W'(SLOW_BASE) : EXP_W'(FAST_BASE)) + EXP_W'(mode.sel);
    limit_m1 = (ONE << exp_sel) - ONE;
    expire   = tick && !halt && !clr && (cnt_q == limit_m1);
    cnt_d    = cnt_q;
    if (clr)               cnt_d = '0;
    else if (tick && !halt) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/keywdt_top.sv
module keywdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned FAST_BASE   = 12,
  parameter int unsigned SLOW_BASE   = 9,
  parameter logic [7:0]  KEY         = 8'hAC,
  parameter logic [7:0]  READBACK    = 8'h9A,
  parameter logic [4:0]  RESET_MODE  = 5'h07,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast_tick,
  input  logic       slow_tick,
  input  logic       wr_en,
  input  logic       addr,
  input  logic       bit_op,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       overflow
);

  localparam int unsigned MAX_BASE = (FAST_BASE > SLOW_BASE) ? FAST_BASE : SLOW_BASE;
  localparam int unsigned CNT_W    = MAX_BASE + 8;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sync_n;
  kwdt_mode_t             mode_w;
  logic                   locked_w, clr_w, trip_w, expire_w;
  logic [CNT_W-1:0]       cnt_w;
  logic                   ovf_q, ovf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[SYNC_STAGES-1];

  kwdt_regs #(
    .KEY       (KEY),
    .READBACK  (READBACK),
    .RESET_MODE(RESET_MODE)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .bit_op     (bit_op),
    .wdata      (wdata),
    .mode       (mode_w),
    .locked     (locked_w),
    .restart_clr(clr_w),
    .trip       (trip_w),
    .rdata      (rdata)
  );

  kwdt_counter #(
    .FAST_BASE(FAST_BASE),
    .SLOW_BASE(SLOW_BASE),
    .CNT_W    (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .fast_tick(fast_tick),
    .slow_tick(slow_tick),
    .mode     (mode_w),
    .clr      (clr_w),
    .halt     (ovf_q),
    .expire   (expire_w),
    .cnt      (cnt_w)
  );

  always_comb ovf_d = ovf_q || trip_w || expire_w;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ovf_q <= 1'b0;
    else             ovf_q <= ovf_d;
  end

  assign overflow = ovf_q;

endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
  parameter int unsigned CNT_W    = 20,
  parameter logic [7:0]  KEY      = 8'hAC,
  parameter logic [7:0]  READBACK = 8'h9A
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             addr,
  input logic             bit_op,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic             overflow,
  input logic             mode_stop,
  input logic             locked,
  input logic [CNT_W-1:0] cnt
);

  a_r7_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && !bit_op && wdata != KEY) |=> overflow);

  a_r8_bit_op: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && bit_op) |=> overflow);

  a_r9_readback: assert property (@(posedge clk) disable iff (!rst_n)
    addr |-> (rdata == READBACK));

  a_r10_second_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && locked) |=> overflow);

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r6_key_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && !bit_op && wdata == KEY && !overflow) |=> (cnt == '0));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stop && !wr_en && !overflow) |=> !overflow);

endmodule

bind keywdt_top kwdt_checker #(
  .CNT_W   (CNT_W),
  .KEY     (KEY),
  .READBACK(READBACK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .bit_op   (bit_op),
  .wdata    (wdata),
  .rdata    (rdata),
  .overflow (overflow),
  .mode_stop(mode_w.stop),
  .locked   (locked_w),
  .cnt      (cnt_w)
);

// File: tb/keywdt_top_tb.sv
module keywdt_top_tb;

  localparam int unsigned FB = 2;
  localparam int unsigned SB = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast_tick = 1'b0, slow_tick = 1'b0;
  logic       wr_en = 1'b0, addr = 1'b0, bit_op = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       overflow;
  int         checks = 0;
  int         failures = 0;

  always #10 clk = ~clk;

  keywdt_top #(.FAST_BASE(FB), .SLOW_BASE(SB)) u_dut (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .wr_en(wr_en), .addr(addr), .bit_op(bit_op), .wdata(wdata),
    .rdata(rdata), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    fast_tick = 0; slow_tick = 0; wr_en = 0; addr = 0; bit_op = 0; wdata = 0;
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input logic b);
    wr_en = 1; addr = a; wdata = d; bit_op = b;
    @(negedge clk);
    wr_en = 0; addr = 0; wdata = 0; bit_op = 0;
  endtask

  task automatic pulse(input logic slow_src);
    if (slow_src) slow_tick = 1; else fast_tick = 1;
    @(negedge clk);
    slow_tick = 0; fast_tick = 0;
  endtask

  task automatic pulses(input logic slow_src, input int n);
    for (int i = 0; i < n; i++) pulse(slow_src);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state and default mode
    do_reset();
    chk("R1 overflow", {7'd0, overflow}, 8'h00);
    addr = 1; #1; chk("R1 restart read", rdata, 8'h9A);
    addr = 0; #1; chk("R1 mode read", rdata, 8'h07);
    pulses(1'b0, (1 << (FB + 7)) - 1);
    chk("R1 default limit-1", {7'd0, overflow}, 8'h00);
    pulse(1'b0);
    chk("R1 default limit", {7'd0, overflow}, 8'h01);

    // R2 R3 R5 sweep all running modes
    for (int m = 0; m < 16; m++) begin
      int lim;
      logic s;
      s   = m[3];
      lim = s ? (1 << (SB + m[2:0])) : (1 << (FB + m[2:0]));
      do_reset();
      wr(1'b0, 8'(m), 1'b0);
      chk("R10 first write", {7'd0, overflow}, 8'h00);
      for (int i = 0; i < lim - 1; i++) begin
        pulse(!s);
        pulse(s);
      end
      chk(s ? "R3 R5 limit-1" : "R2 R5 limit-1", {7'd0, overflow}, 8'h00);
      pulse(s);
      chk(s ? "R3 limit" : "R2 limit", {7'd0, overflow}, 8'h01);
    end

    // R4 stop modes
    for (int k = 0; k < 3; k++) begin
      logic [7:0] sm;
      sm = (k == 0) ? 8'h10 : (k == 1) ? 8'h18 : 8'h1F;
      do_reset();
      wr(1'b0, sm, 1'b0);
      for (int i = 0; i < 600; i++) begin
        fast_tick = 1; slow_tick = 1;
        @(negedge clk);
      end
      fast_tick = 0; slow_tick = 0;
      chk("R4 stopped", {7'd0, overflow}, 8'h00);
    end

    // R6 key restart
    do_reset();
    wr(1'b0, 8'h00, 1'b0);
    pulses(1'b0, 3);
    wr(1'b1, 8'hAC, 1'b0);
    chk("R6 key no trip", {7'd0, overflow}, 8'h00);
    pulses(1'b0, 3);
    chk("R6 after restart limit-1", {7'd0, overflow}, 8'h00);
    pulse(1'b0);
    chk("R6 after restart limit", {7'd0, overflow}, 8'h01);

    // R6 key wins over a simultaneous tick
    do_reset();
    wr(1'b0, 8'h00, 1'b0);
    pulses(1'b0, 3);
    fast_tick = 1;
    wr(1'b1, 8'hAC, 1'b0);
    fast_tick = 0;
    pulses(1'b0, 3);
    chk("R6 key with tick limit-1", {7'd0, overflow}, 8'h00);
    pulse(1'b0);
    chk("R6 key with tick limit", {7'd0, overflow}, 8'h01);

    // R7 every non-key byte trips
    for (int v = 0; v < 256; v++) begin
      if (v != 8'hAC) begin
        do_reset();
        wr(1'b1, 8'(v), 1'b0);
        chk("R7 bad key", {7'd0, overflow}, 8'h01);
      end
    end

    // R8 bit operation trips even with the key
    do_reset();
    wr(1'b1, 8'hAC, 1'b1);
    chk("R8 bit op", {7'd0, overflow}, 8'h01);

    // R9 readback fixed
    do_reset();
    wr(1'b1, 8'hAC, 1'b0);
    addr = 1; #1; chk("R9 after key", rdata, 8'h9A);
    addr = 0;
    wr(1'b0, 8'h0B, 1'b0);
    #1; chk("R10 mode readback", rdata, 8'h0B);
    wr(1'b1, 8'h55, 1'b0);
    addr = 1; #1; chk("R9 after bad write", rdata, 8'h9A);
    addr = 0;

    // R10 second mode write trips
    do_reset();
    wr(1'b0, 8'h03, 1'b0);
    chk("R10 first ok", {7'd0, overflow}, 8'h00);
    wr(1'b0, 8'h03, 1'b0);
    chk("R10 second trips", {7'd0, overflow}, 8'h01);

    // R11 sticky, key after overflow ignored
    wr(1'b1, 8'hAC, 1'b0);
    chk("R11 key after overflow", {7'd0, overflow}, 8'h01);
    repeat (20) @(negedge clk);
    chk("R11 held", {7'd0, overflow}, 8'h01);
    do_reset();
    chk("R11 cleared by reset", {7'd0, overflow}, 8'h00);

    // R10 first mode write clears the counter
    do_reset();
    pulses(1'b0, 500);
    wr(1'b0, 8'h07, 1'b0);
    pulses(1'b0, (1 << (FB + 7)) - 1);
    chk("R10 clear limit-1", {7'd0, overflow}, 8'h00);
    pulse(1'b0);
    chk("R10 clear limit", {7'd0, overflow}, 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule